// File: doc/BRIEF.md
# Extended-Range Synchronization Counter with Seed Gating

This block holds the 16-bit synchronization counter of a rolling-code transmitter. The counter advances by one for each transmission. Two sticky overflow flags stretch the usable count range beyond a single 16-bit pass. Each flag that was loaded as 1 is consumed on a later full wrap of the counter. When the counter wraps and no flag is left, the block raises a sticky range-exhausted indication.

The block also decides whether a seed code word may be sent. Two configuration bits choose one of three seed modes: never, always, or a temporary permission. The temporary permission lasts only until the low seven counter bits first roll over. After that it stays revoked until the configuration is loaded again.

A production or host path loads the counter value, the initial flags and the seed configuration through a single load strobe. All outputs are registered and change on the same clock edge.

Top module: `rc_sync_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `cnt_o`=0, `ovf_o`=0, `exhausted_o`=0 and `seed_ok_o`=0.
- R2: `load_i` high at an edge sets `cnt_o` to `load_cnt_i` and `ovf_o` to `load_ovf_i`. It latches the seed configuration and clears both the exhausted indication and the temporary-seed expiry. An `inc_i` in the same cycle is ignored.
- R3: `inc_i` high without `load_i` makes `cnt_o` one greater, modulo 65,536, after the edge. With neither strobe high, `cnt_o` holds.
- R4: An increment from FFFFh to 0000h clears the lowest-numbered set bit of `ovf_o`, so bit 0 is cleared before bit 1.
- R5: Without a load, no bit of `ovf_o` ever goes from 0 to 1. Once both bits are 0, they stay 0 through every later wrap.
- R6: An increment from FFFFh to 0000h while `ovf_o` is 00 sets `exhausted_o` one edge later. It then stays set until a load or reset. With both flags loaded as 1, this takes 196,608 increments from 0000h; with one flag, 131,072.
- R7: Seed mode encoding: with `load_seed_en_i`=0 at the load, `seed_ok_o` is 0. With `load_seed_en_i`=1 and `load_seed_tmp_i`=0, `seed_ok_o` is 1 whatever the counter does.
- R8: With `load_seed_en_i`=1 and `load_seed_tmp_i`=1, `seed_ok_o` is 1 after the load. It falls on the edge where an increment takes `cnt_o[6:0]` from 7Fh to 00h, and stays 0 until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | 1 | Increment strobe, one per transmission |
| load_i | input | 1 | Load strobe for counter, flags and seed configuration |
| load_cnt_i | input | 16 | Counter value to load |
| load_ovf_i | input | 2 | Initial overflow flags |
| load_seed_en_i | input | 1 | Seed enable configuration bit |
| load_seed_tmp_i | input | 1 | Temporary seed configuration bit |
| cnt_o | output | 16 | Synchronization counter |
| ovf_o | output | 2 | Remaining overflow flags |
| exhausted_o | output | 1 | Sticky range-exhausted indication |
| seed_ok_o | output | 1 | Seed code word permitted |

## Verification
The assertions check the per-edge rules on every cycle. These are: the load value appearing, the counter stepping by one or holding, flags never rising without a load, a wrap consuming exactly one flag, and exhausted rising only after a wrap with no flags. They also check that seed permission only ever rises through a load, and that a disabled configuration blocks it.

Only the bench scenarios can show the history-dependent behaviour. This covers the temporary permission surviving until the first 7Fh rollover and then staying revoked across later rollovers, the exhausted indication persisting, and the fixed order in which the flags are consumed across successive wraps.

// File: rtl/rc_sync_pkg.sv
package rc_sync_pkg;

  typedef enum logic [1:0] {
    SEED_NEVER  = 2'd0,
    SEED_ALWAYS = 2'd1,
    SEED_TEMP   = 2'd2
  } seed_mode_e;

  // Map the two configuration bits onto a seed mode; enable low wins.
  function automatic seed_mode_e decode_seed(input logic en, input logic tmp);
    if (!en)      return SEED_NEVER;
    else if (tmp) return SEED_TEMP;
    else          return SEED_ALWAYS;
  endfunction

endpackage

// File: rtl/rc_count_core.sv
module rc_count_core #(
  parameter int CNT_W = 16,
  parameter int WIN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             full_wrap,
  output logic             win_wrap
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [WIN_W-1:0] WIN_ONES = {WIN_W{1'b1}};

  logic step;
  assign step      = inc && !load;
  assign full_wrap = step && (cnt == ALL_ONES);
  assign win_wrap  = step && (cnt[WIN_W-1:0] == WIN_ONES);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rc_ovf_track.sv
module rc_ovf_track #(
  parameter int OVF_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OVF_N-1:0] load_flags,
  input  logic             full_wrap,
  output logic [OVF_N-1:0] flags,
  output logic             exhausted
);
  logic [OVF_N-1:0] lowest_set;
  logic             none_left;

  // One-hot mask of the lowest set flag, built per bit.
  generate
    for (genvar i = 0; i < OVF_N; i++) begin : g_low
      if (i == 0) begin : g_first
        assign lowest_set[i] = flags[i];
      end else begin : g_rest
        assign lowest_set[i] = flags[i] && (flags[i-1:0] == '0);
      end
    end
  endgenerate

  assign none_left = (flags == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      exhausted <= 1'b0;
    end else if (load) begin
      flags     <= load_flags;
      exhausted <= 1'b0;
    end else if (full_wrap) begin
      flags <= flags & ~lowest_set;
      if (none_left) exhausted <= 1'b1;
    end
  end
endmodule

// File: rtl/rc_seed_gate.sv
module rc_seed_gate
  import rc_sync_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_en,
  input  logic load_tmp,
  input  logic win_wrap,
  output logic seed_ok
);
  seed_mode_e mode_q, mode_d;
  logic       expired_q, expired_d;

  always_comb begin
    mode_d    = mode_q;
    expired_d = expired_q;
    if (load) begin
      mode_d    = decode_seed(load_en, load_tmp);
      expired_d = 1'b0;
    end else if (win_wrap && mode_q == SEED_TEMP) begin
      expired_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= SEED_NEVER;
      expired_q <= 1'b0;
      seed_ok   <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      expired_q <= expired_d;
      seed_ok   <= (mode_d == SEED_ALWAYS) || (mode_d == SEED_TEMP && !expired_d);
    end
  end
endmodule

// File: rtl/rc_sync_counter.sv
module rc_sync_counter #(
  parameter int CNT_W = 16,
  parameter int OVF_N = 2,
  parameter int WIN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic [OVF_N-1:0] load_ovf_i,
  input  logic             load_seed_en_i,
  input  logic             load_seed_tmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [OVF_N-1:0] ovf_o,
  output logic             exhausted_o,
  output logic             seed_ok_o
);
  logic full_wrap, win_wrap;

  rc_count_core #(.CNT_W(CNT_W), .WIN_W(WIN_W)) core_i (
    .clk(clk), .rst(rst), .inc(inc_i), .load(load_i), .load_val(load_cnt_i),
    .cnt(cnt_o), .full_wrap(full_wrap), .win_wrap(win_wrap)
  );

  rc_ovf_track #(.OVF_N(OVF_N)) ovf_i (
    .clk(clk), .rst(rst), .load(load_i), .load_flags(load_ovf_i),
    .full_wrap(full_wrap), .flags(ovf_o), .exhausted(exhausted_o)
  );

  rc_seed_gate seed_i (
    .clk(clk), .rst(rst), .load(load_i), .load_en(load_seed_en_i),
    .load_tmp(load_seed_tmp_i), .win_wrap(win_wrap), .seed_ok(seed_ok_o)
  );
endmodule

// File: rtl/rc_sync_counter_chk.sv
module rc_sync_counter_chk #(
  parameter int CNT_W = 16,
  parameter int OVF_N = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             inc_i,
  input logic             load_i,
  input logic [CNT_W-1:0] load_cnt_i,
  input logic [OVF_N-1:0] load_ovf_i,
  input logic             load_seed_en_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [OVF_N-1:0] ovf_o,
  input logic             exhausted_o,
  input logic             seed_ok_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cnt_o == '0 && ovf_o == '0 && !exhausted_o && !seed_ok_o));

  assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_o == $past(load_cnt_i) && ovf_o == $past(load_ovf_i) && !exhausted_o));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !load_i) |=> $stable(cnt_o));

  assert_flag_consumed_R4: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i && cnt_o == TOP && ovf_o != '0)
      |=> $countones(ovf_o) + 1 == $countones($past(ovf_o)));

  assert_no_flag_rise_R5: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (ovf_o & ~$past(ovf_o)) == '0);

  assert_exhaust_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(exhausted_o) |-> $past(inc_i && !load_i && cnt_o == TOP && ovf_o == '0));

  assert_seed_off_R7: assert property (@(posedge clk) disable iff (rst)
    (load_i && !load_seed_en_i) |=> !seed_ok_o);

  assert_seed_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(seed_ok_o) |-> $past(load_i));
endmodule

bind rc_sync_counter rc_sync_counter_chk #(.CNT_W(CNT_W), .OVF_N(OVF_N)) chk_i (
  .clk(clk), .rst(rst), .inc_i(inc_i), .load_i(load_i), .load_cnt_i(load_cnt_i),
  .load_ovf_i(load_ovf_i), .load_seed_en_i(load_seed_en_i), .cnt_o(cnt_o),
  .ovf_o(ovf_o), .exhausted_o(exhausted_o), .seed_ok_o(seed_ok_o)
);

// File: tb/rc_sync_counter_tb_top.sv
module rc_sync_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, inc_i, load_i, load_seed_en_i, load_seed_tmp_i;
  logic [15:0] load_cnt_i;
  logic [1:0]  load_ovf_i;
  logic [15:0] cnt_o;
  logic [1:0]  ovf_o;
  logic        exhausted_o, seed_ok_o;

  int n_chk = 0;
  int n_bad = 0;

  // Reference state
  logic [15:0] m_cnt;
  logic [1:0]  m_ovf;
  logic        m_exh, m_en, m_tmp, m_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  rc_sync_counter dut_i (
    .clk(clk), .rst(rst), .inc_i(inc_i), .load_i(load_i), .load_cnt_i(load_cnt_i),
    .load_ovf_i(load_ovf_i), .load_seed_en_i(load_seed_en_i),
    .load_seed_tmp_i(load_seed_tmp_i), .cnt_o(cnt_o), .ovf_o(ovf_o),
    .exhausted_o(exhausted_o), .seed_ok_o(seed_ok_o)
  );

  function automatic logic exp_seed();
    return m_en && (!m_tmp || !m_exp);
  endfunction

  function automatic logic [1:0] drop_lowest(input logic [1:0] f);
    if (f[0]) return {f[1], 1'b0};
    return 2'b00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " cnt"}, 32'(cnt_o), 32'(m_cnt));
    check({tag, " ovf"}, 32'(ovf_o), 32'(m_ovf));
    check({tag, " exhausted"}, 32'(exhausted_o), 32'(m_exh));
    check({tag, " seed_ok"}, 32'(seed_ok_o), 32'(exp_seed()));
  endtask

  // One clock: drive at negedge, update model at the edge, compare at next negedge.
  task automatic step(input logic inc, input logic ld, input logic [15:0] lv,
                      input logic [1:0] lf, input logic en, input logic tmp,
                      input string tag);
    inc_i = inc; load_i = ld; load_cnt_i = lv; load_ovf_i = lf;
    load_seed_en_i = en; load_seed_tmp_i = tmp;
    @(posedge clk);
    if (ld) begin
      m_cnt = lv; m_ovf = lf; m_en = en; m_tmp = tmp; m_exp = 1'b0; m_exh = 1'b0;
    end else if (inc) begin
      if (m_cnt[6:0] == 7'h7f && m_en && m_tmp) m_exp = 1'b1;
      if (m_cnt == 16'hffff) begin
        if (m_ovf == 2'b00) m_exh = 1'b1;
        m_ovf = drop_lowest(m_ovf);
      end
      m_cnt = m_cnt + 16'd1;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1357));
    rst = 1'b1; inc_i = 0; load_i = 0; load_cnt_i = 0; load_ovf_i = 0;
    load_seed_en_i = 0; load_seed_tmp_i = 0;
    m_cnt = 0; m_ovf = 0; m_exh = 0; m_en = 0; m_tmp = 0; m_exp = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_all("R1 reset");
    rst = 1'b0;

    // R2: load beats a simultaneous increment
    step(1, 1, 16'h1234, 2'b11, 1, 0, "R2 load+inc");
    step(0, 0, 0, 0, 0, 0, "R3 hold");
    step(1, 0, 0, 0, 0, 0, "R3 step");
    // R4: flag 0 consumed first, then flag 1
    step(0, 1, 16'hffff, 2'b11, 1, 0, "R2 load top");
    step(1, 0, 0, 0, 0, 0, "R4 first wrap");
    check("R4 ovf after first wrap", 32'(ovf_o), 32'h2);
    step(0, 1, 16'hffff, 2'b10, 1, 0, "R2 load top");
    step(1, 0, 0, 0, 0, 0, "R4 second wrap");
    check("R5 ovf after second wrap", 32'(ovf_o), 32'h0);
    // R6: wrap with no flags sets sticky exhausted
    step(0, 1, 16'hfffe, 2'b00, 1, 0, "R2 load");
    step(1, 0, 0, 0, 0, 0, "R6 near top");
    step(1, 0, 0, 0, 0, 0, "R6 wrap empty");
    check("R6 exhausted set", 32'(exhausted_o), 32'h1);
    for (int i = 0; i < 300; i++) step(1, 0, 0, 0, 0, 0, "R6 sticky");
    check("R7 always mode keeps seed", 32'(seed_ok_o), 32'h1);
    // R8: temporary permission revoked at first low-7 rollover
    step(0, 1, 16'h007e, 2'b11, 1, 1, "R8 load temp");
    check("R8 seed after load", 32'(seed_ok_o), 32'h1);
    step(1, 0, 0, 0, 0, 0, "R8 to 7f");
    step(1, 0, 0, 0, 0, 0, "R8 rollover");
    check("R8 seed revoked", 32'(seed_ok_o), 32'h0);
    for (int i = 0; i < 260; i++) step(1, 0, 0, 0, 0, 0, "R8 stays revoked");
    step(0, 1, 16'h0010, 2'b00, 0, 1, "R7 disabled");
    check("R7 seed disabled", 32'(seed_ok_o), 32'h0);

    // Constrained random mix
    for (int i = 0; i < 20000; i++) begin
      logic [15:0] lv;
      r = $urandom;
      case (r[9:8])
        2'd0: lv = 16'hfff0 | 16'(r[19:16]);
        2'd1: lv = {r[31:23], 7'h7c} | 16'(r[21:20]);
        default: lv = r[31:16];
      endcase
      step(r[3:0] != 4'd0, r[7:4] == 4'd0, lv, r[11:10], r[12], r[13], "R2-mix");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule